// File: doc/BRIEF.md
# Cache Performance Monitor Counter Unit

This block counts activity inside a shared cache so that software can profile it. It holds a configurable number (up to eight) of 32-bit event counters and one free-running 64-bit cycle counter. Event selection works in two stages. A single 64-bit selection register keeps one 8-bit event code for each of eight event groups. Each event counter then names the group it follows. On every clock the unit picks, for each group, the one pulse line chosen by that group's code, out of 256 lines per group. A counter advances when the pulse of its group fires.

Software drives the unit through a simple word-addressed register port: a 12-bit address, 64-bit write data with a write strobe, and 64-bit read data returned one clock after a read strobe. Three 32-bit bitmaps control the counters: counting enable, interrupt enable and overflow status. Each bitmap has its own set address and clear address. Event counter n owns bit n of every bitmap, and the cycle counter owns bit 31. When a counter wraps, its overflow bit is latched, and a level interrupt stays high while any pending overflow has its interrupt enabled. Counter values are writable, so software can preload a value just below the wrap point and receive an interrupt after a chosen number of events.

Top module: `cache_perf_monitor`

## Requirements
- R1: After synchronous reset, all counters, bitmaps and configuration registers are zero and `irq_o` is low. The control register at 0x400 reads back NUM_EVT in bits 15:11 at all times.
- R2: A write to 0x400 loads bit 0 as the global count enable. Write-data bit 1 zeroes every event counter, and bit 2 zeroes the cycle counter, so writing 0x6 zeroes all of them. Zeroing takes priority over counting in the same cycle.
- R3: The enable bitmap has its clear address at 0x403 and its set address at 0x404. The interrupt-enable bitmap uses 0x405 (clear) and 0x406 (set), and the overflow bitmap uses 0x407 (clear) and 0x408 (set). A 1 in the written data acts on that bit only. Bit n stands for event counter n and bit 31 for the cycle counter. Reads at either address of a pair return the bitmap, and bits with no counter behind them read 0.
- R4: The selection register at 0x410 keeps the code of group g in bits 8g+7:8g, and bit 63 is its master enable. Event counter n increments by one in a cycle only when all of these hold: the global enable is 1, enable bit n is 1, bit 63 is 1, and `evt_pulse_i[256*g + code_g]` is 1, where g is the counter's type value.
- R5: The 64-bit cycle counter at 0x40A increments on every cycle in which the global enable and enable bit 31 are both 1. Its count-control register at 0x409 keeps 32 written bits and has no other effect.
- R6: Event counter n has a block of registers at 0x420 + 0x10·n: count control at offset 0 (32 bits, kept only), value at offset 1 (32 bits, writable), filter at offset 3 (32 bits, kept only), and type at offset 4 (3 bits, the group number).
- R7: An event counter at 0xFFFFFFFF that increments becomes 0, and the cycle counter at all-ones that increments becomes 0. On the same clock edge, the counter's overflow bit is set.
- R8: `irq_o` is high exactly while some bit is 1 in both the overflow bitmap and the interrupt-enable bitmap.
- R9: When a counter wraps in the same cycle as a software write that clears its overflow bit, the bit ends up set.
- R10: A software write to a counter value in the same cycle as an increment loads the written value, with no increment.
- R11: Reads of unmapped addresses return zero. This covers offset 2 of a counter block and the blocks of counters at or above NUM_EVT. Writes to these addresses change nothing.
- R12: `rd_data_o` presents the addressed register as sampled on the clock edge at which `rd_en_i` is high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 12 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 64 | Read data, registered |
| evt_pulse_i | input | 2048 | Event pulses, 256 lines per group, group g at lines 256g..256g+255 |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The overflow bitmap has two writers: the hardware wrap detection and the software clear address. Both can act on the same bit in the same cycle. The bench preloads a counter to all-ones and sets its overflow bit by software. In a single cycle it then raises the selected event pulse and writes that bit to the clear address. After that edge it reads the overflow bitmap, and the bit must still be set. In the same way, the bench writes a counter value in the very cycle in which the counter's event fires, and the read-back must equal the written value.

// File: rtl/cpmu_pkg.sv
// Package: shared constants and the internal register-port request type for
// the cache performance monitor. Assumes a 12-bit word address space.
package cpmu_pkg;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned GROUPS    = 8;
    localparam int unsigned CODE_W    = 8;
    localparam int unsigned CODES     = 1 << CODE_W;
    localparam int unsigned GRP_IDX_W = $clog2(GROUPS);
    localparam int unsigned MAP_W     = 32;
    localparam int unsigned CYC_BIT   = 31;

    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 12'h403;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 12'h404;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h405;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h406;
    localparam logic [ADDR_W-1:0] A_OV_CLR  = 12'h407;
    localparam logic [ADDR_W-1:0] A_OV_SET  = 12'h408;
    localparam logic [ADDR_W-1:0] A_CYC_CTL = 12'h409;
    localparam logic [ADDR_W-1:0] A_CYC_VAL = 12'h40A;
    localparam logic [ADDR_W-1:0] A_EVSEL   = 12'h410;

    // Upper eight address bits of the register block of event counter 0.
    localparam logic [7:0] SLOT_BLK0 = 8'h42;
    localparam logic [3:0] OFF_CTL   = 4'h0;
    localparam logic [3:0] OFF_VAL   = 4'h1;
    localparam logic [3:0] OFF_FLT   = 4'h3;
    localparam logic [3:0] OFF_TYP   = 4'h4;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_ZEV_BIT  = 1;
    localparam int unsigned CTRL_ZCYC_BIT = 2;
    localparam int unsigned CTRL_NUM_LSB  = 11;
    localparam int unsigned CTRL_NUM_W    = 5;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;
endpackage

// File: rtl/cpmu_evsel.sv
// Event selection stage: stores the 64-bit selection register and, for each
// group, forwards the one pulse line chosen by that group's 8-bit code.
// Assumes the event pulses are synchronous to clk and one cycle wide.
module cpmu_evsel
    import cpmu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  bus_wr_t                   req,
    input  logic [GROUPS*CODES-1:0]   evt_i,
    output logic                      master_o,
    output logic [GROUPS-1:0]         grp_fire_o,
    output logic [DATA_W-1:0]         rd_data_o
);
    logic [DATA_W-1:0] sel_q;

    // Load the selection register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sel_q <= '0;
        else if (req.wr && req.addr == A_EVSEL)  sel_q <= req.wdata;
    end

    // Per-group multiplexer from 256 pulse lines down to one.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CODES-1:0]  lines;
        logic [CODE_W-1:0] code;
        assign lines         = evt_i[g*CODES +: CODES];
        assign code          = sel_q[g*CODE_W +: CODE_W];
        assign grp_fire_o[g] = lines[code];
    end

    assign master_o  = sel_q[DATA_W-1];
    assign rd_data_o = (req.addr == A_EVSEL) ? sel_q : '0;

    // R4: no group fires while every pulse line is quiet.
    a_r4_no_fire_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |-> (grp_fire_o == '0));
endmodule

// File: rtl/cpmu_bitmaps.sv
// Enable, interrupt-enable and overflow bitmaps with separate set and clear
// addresses, plus the level interrupt. Hardware wrap flags set overflow bits
// and win over a software clear in the same cycle. Bits outside IMPL_MASK
// have no storage and read as zero.
module cpmu_bitmaps
    import cpmu_pkg::*;
#(
    parameter logic [MAP_W-1:0] IMPL_MASK = 32'h8000_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_wr_t           req,
    input  logic [MAP_W-1:0]  hw_ovf_i,
    output logic [MAP_W-1:0]  en_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [MAP_W-1:0] en_q, ie_q, ov_q;
    logic [MAP_W-1:0] wbits;
    logic             unused_hi;

    assign wbits     = req.wdata[MAP_W-1:0];
    assign unused_hi = ^req.wdata[DATA_W-1:MAP_W];

    // Counting-enable bitmap: set and clear by address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  en_q <= '0;
        else if (req.wr && req.addr == A_EN_SET)     en_q <= (en_q | wbits) & IMPL_MASK;
        else if (req.wr && req.addr == A_EN_CLR)     en_q <= en_q & ~wbits;
    end

    // Interrupt-enable bitmap: set and clear by address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ie_q <= '0;
        else if (req.wr && req.addr == A_IE_SET)     ie_q <= (ie_q | wbits) & IMPL_MASK;
        else if (req.wr && req.addr == A_IE_CLR)     ie_q <= ie_q & ~wbits;
    end

    // Overflow bitmap: software set/clear, hardware wrap set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ((ov_q
                      & ~((req.wr && req.addr == A_OV_CLR) ? wbits : '0))
                      |  ((req.wr && req.addr == A_OV_SET) ? wbits : '0)
                      |  hw_ovf_i) & IMPL_MASK;
        end
    end

    // Read-back of whichever bitmap is addressed.
    always_comb begin
        rd_data_o = '0;
        case (req.addr)
            A_EN_CLR, A_EN_SET: rd_data_o = DATA_W'(en_q);
            A_IE_CLR, A_IE_SET: rd_data_o = DATA_W'(ie_q);
            A_OV_CLR, A_OV_SET: rd_data_o = DATA_W'(ov_q);
            default:            rd_data_o = '0;
        endcase
    end

    assign en_o  = en_q;
    assign irq_o = |(ov_q & ie_q);

    // R9: a hardware wrap flag always leaves its overflow bit set.
    a_r9_wrap_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ovf_i != '0) |=> ((ov_q & $past(hw_ovf_i)) == $past(hw_ovf_i)));
    // R3: a clear write with no wrap removes the named enable bits.
    a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && req.addr == A_EN_CLR) |=> ((en_q & $past(wbits)) == '0));
endmodule

// File: rtl/cpmu_evt_slot.sv
// One event counter with its register block: count control and filter words
// (kept only), a writable value, and a group-select type. Increments when
// run_i is high and the selected group fires. Flags a wrap combinationally
// so the overflow bit is set on the same edge the value returns to zero.
module cpmu_evt_slot
    import cpmu_pkg::*;
#(
    parameter int unsigned IDX   = 0,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_wr_t           req,
    input  logic              zero_i,
    input  logic              run_i,
    input  logic [GROUPS-1:0] grp_fire_i,
    output logic              wrap_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [7:0] MY_BLK = SLOT_BLK0 + 8'(IDX);

    logic                 hit_blk;
    logic                 wr_ctl, wr_val, wr_flt, wr_typ;
    logic [CNT_W-1:0]     cnt_q, ctl_q, flt_q, wr_word;
    logic [GRP_IDX_W-1:0] typ_q;
    logic                 inc;
    logic                 unused_hi;

    assign hit_blk   = (req.addr[ADDR_W-1:4] == MY_BLK);
    assign wr_ctl    = req.wr && hit_blk && req.addr[3:0] == OFF_CTL;
    assign wr_val    = req.wr && hit_blk && req.addr[3:0] == OFF_VAL;
    assign wr_flt    = req.wr && hit_blk && req.addr[3:0] == OFF_FLT;
    assign wr_typ    = req.wr && hit_blk && req.addr[3:0] == OFF_TYP;
    assign wr_word   = req.wdata[CNT_W-1:0];
    assign unused_hi = ^req.wdata[DATA_W-1:CNT_W];
    assign inc       = run_i && grp_fire_i[typ_q];

    // Count value: zeroing, then software load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (zero_i)  cnt_q <= '0;
        else if (wr_val)  cnt_q <= wr_word;
        else if (inc)     cnt_q <= cnt_q + CNT_W'(1);
    end

    // Configuration words: count control, filter and group type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            flt_q <= '0;
            typ_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= wr_word;
            if (wr_flt) flt_q <= wr_word;
            if (wr_typ) typ_q <= wr_word[GRP_IDX_W-1:0];
        end
    end

    assign wrap_o = inc && !zero_i && !wr_val && (&cnt_q);

    // Read-back of the addressed word in this block; zero elsewhere.
    always_comb begin
        rd_data_o = '0;
        if (hit_blk) begin
            case (req.addr[3:0])
                OFF_CTL: rd_data_o = DATA_W'(ctl_q);
                OFF_VAL: rd_data_o = DATA_W'(cnt_q);
                OFF_FLT: rd_data_o = DATA_W'(flt_q);
                OFF_TYP: rd_data_o = DATA_W'(typ_q);
                default: rd_data_o = '0;
            endcase
        end
    end

    // R4: the value holds when the counter is not running and nothing writes it.
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_val && !zero_i) |=> $stable(cnt_q));
    // R7: a flagged wrap leaves the counter at zero.
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
    // R10: a software load wins over a same-cycle increment.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val && !zero_i) |=> (cnt_q == $past(wr_word)));
endmodule

// File: rtl/cache_perf_monitor.sv
// Top of the cache performance monitor: register port, global control, the
// 64-bit cycle counter, the event selection stage, NUM_EVT event counter
// slots, the bitmaps and the registered read multiplexer.
// Assumes one register access per cycle and NUM_EVT between 1 and 8.
module cache_perf_monitor
    import cpmu_pkg::*;
#(
    parameter int unsigned NUM_EVT = 8,
    parameter int unsigned EVT_W   = 32,
    parameter int unsigned CYC_W   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [11:0]             addr_i,
    input  logic                    wr_en_i,
    input  logic [63:0]             wr_data_i,
    input  logic                    rd_en_i,
    output logic [63:0]             rd_data_o,
    input  logic [2047:0]           evt_pulse_i,
    output logic                    irq_o
);
    localparam logic [MAP_W-1:0] IMPL_MASK =
        (MAP_W'(1) << CYC_BIT) | ((MAP_W'(1) << NUM_EVT) - MAP_W'(1));

    bus_wr_t            req;
    logic               glob_en_q;
    logic               wr_ctrl, zero_evt, zero_cyc, wr_cyc_val, wr_cyc_ctl;
    logic [CYC_W-1:0]   cyc_q;
    logic [31:0]        cyc_ctl_q;
    logic               cyc_run, cyc_wrap;
    logic [MAP_W-1:0]   en_map, hw_ovf;
    logic               sel_master;
    logic [GROUPS-1:0]  grp_fire;
    logic [NUM_EVT-1:0] slot_wrap;
    logic [DATA_W-1:0]  slot_rd [NUM_EVT];
    logic [DATA_W-1:0]  evsel_rd, map_rd, local_rd, rd_comb, rd_q;

    assign req.wr    = wr_en_i;
    assign req.addr  = addr_i;
    assign req.wdata = wr_data_i;

    assign wr_ctrl    = wr_en_i && addr_i == A_CTRL;
    assign zero_evt   = wr_ctrl && wr_data_i[CTRL_ZEV_BIT];
    assign zero_cyc   = wr_ctrl && wr_data_i[CTRL_ZCYC_BIT];
    assign wr_cyc_val = wr_en_i && addr_i == A_CYC_VAL;
    assign wr_cyc_ctl = wr_en_i && addr_i == A_CYC_CTL;

    // Global count enable from control bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        glob_en_q <= 1'b0;
        else if (wr_ctrl)  glob_en_q <= wr_data_i[CTRL_EN_BIT];
    end

    // Cycle counter: zeroing, then software load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_q <= '0;
        else if (zero_cyc)   cyc_q <= '0;
        else if (wr_cyc_val) cyc_q <= wr_data_i[CYC_W-1:0];
        else if (cyc_run)    cyc_q <= cyc_q + CYC_W'(1);
    end

    // Cycle counter count-control word, kept only.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_ctl_q <= '0;
        else if (wr_cyc_ctl) cyc_ctl_q <= wr_data_i[31:0];
    end

    assign cyc_run  = glob_en_q && en_map[CYC_BIT];
    assign cyc_wrap = cyc_run && !zero_cyc && !wr_cyc_val && (&cyc_q);

    cpmu_evsel u_evsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .evt_i      (evt_pulse_i),
        .master_o   (sel_master),
        .grp_fire_o (grp_fire),
        .rd_data_o  (evsel_rd)
    );

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_slot
        cpmu_evt_slot #(
            .IDX   (n),
            .CNT_W (EVT_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req),
            .zero_i     (zero_evt),
            .run_i      (glob_en_q && en_map[n] && sel_master),
            .grp_fire_i (grp_fire),
            .wrap_o     (slot_wrap[n]),
            .rd_data_o  (slot_rd[n])
        );
    end

    // Gather wrap flags into bitmap positions.
    always_comb begin
        hw_ovf = '0;
        for (int n = 0; n < NUM_EVT; n++) hw_ovf[n] = slot_wrap[n];
        hw_ovf[CYC_BIT] = cyc_wrap;
    end

    cpmu_bitmaps #(
        .IMPL_MASK (IMPL_MASK)
    ) u_maps (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .hw_ovf_i  (hw_ovf),
        .en_o      (en_map),
        .irq_o     (irq_o),
        .rd_data_o (map_rd)
    );

    // Read-back of registers held in this module.
    always_comb begin
        local_rd = '0;
        case (addr_i)
            A_CTRL: begin
                local_rd[CTRL_NUM_LSB +: CTRL_NUM_W] = CTRL_NUM_W'(NUM_EVT);
                local_rd[CTRL_EN_BIT]                = glob_en_q;
            end
            A_CYC_CTL: local_rd = DATA_W'(cyc_ctl_q);
            A_CYC_VAL: local_rd = DATA_W'(cyc_q);
            default:   local_rd = '0;
        endcase
    end

    // OR of all sources; each returns zero when not addressed.
    always_comb begin
        rd_comb = local_rd | evsel_rd | map_rd;
        for (int n = 0; n < NUM_EVT; n++) rd_comb = rd_comb | slot_rd[n];
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_comb;
    end

    assign rd_data_o = rd_q;

    // R5: a running cycle counter advances by one when not written or zeroed.
    a_r5_cycle_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_run && !zero_cyc && !wr_cyc_val) |=> (cyc_q == $past(cyc_q) + CYC_W'(1)));
    // R2: zeroing the cycle counter leaves it at zero.
    a_r2_cycle_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cyc |=> (cyc_q == '0));
    // R12: read data changes only after a read strobe.
    a_r12_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/cache_perf_monitor_tb.sv
// Self-checking bench: a table of write/read-back vectors, then directed tests.
module cache_perf_monitor_tb;
    localparam int NEV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   addr_i = '0;
    logic          wr_en_i = 1'b0;
    logic [63:0]   wr_data_i = '0;
    logic          rd_en_i = 1'b0;
    logic [63:0]   rd_data_o;
    logic [2047:0] evt_pulse_i = '0;
    logic          irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cache_perf_monitor #(.NUM_EVT(NEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .evt_pulse_i(evt_pulse_i), .irq_o(irq_o)
    );

    // Write/read-back vectors: {address, write data, expected read}.
    localparam logic [139:0] VECS [0:13] = '{
        {12'h410, 64'h80A5_0000_0000_3C11, 64'h80A5_0000_0000_3C11}, // R4
        {12'h424, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0005}, // R6 type
        {12'h423, 64'h0000_0001_000E_0007, 64'h0000_0000_000E_0007}, // R6 filter
        {12'h420, 64'h0000_0000_1234_5678, 64'h0000_0000_1234_5678}, // R6 ctl
        {12'h421, 64'h0000_0000_DEAD_BEEF, 64'h0000_0000_DEAD_BEEF}, // R6 value
        {12'h451, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005}, // R6 slot 3
        {12'h409, 64'h0000_0000_0000_ABCD, 64'h0000_0000_0000_ABCD}, // R5 ctl
        {12'h40A, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF}, // R5 value
        {12'h404, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_003F}, // R3 set
        {12'h403, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_003E}, // R3 clear
        {12'h406, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003}, // R3 ie
        {12'h481, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0000}, // R11 slot 6
        {12'h422, 64'h0000_0000_0000_0009, 64'h0000_0000_0000_0000}, // R11 gap
        {12'h400, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_3000}  // R1 count
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic pulse(input int line, input int times);
        for (int k = 0; k < times; k++) begin
            @(negedge clk);
            evt_pulse_i[line] = 1'b1;
            @(negedge clk);
            evt_pulse_i[line] = 1'b0;
        end
    endtask

    function automatic int ev(input int g, input int c);
        return g * 256 + c;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(12'h400, v); chk("R1 control", v, 64'h3000);
        rd(12'h40A, v); chk("R1 cycle", v, 64'h0);
        rd(12'h404, v); chk("R1 enable map", v, 64'h0);
        chk("R1 irq", {63'd0, irq_o}, 64'h0);

        // Table walk: write then read back.
        foreach (VECS[i]) begin
            wr(VECS[i][139:128], VECS[i][127:64]);
            rd(VECS[i][139:128], v);
            chk($sformatf("vector %0d (R3/R4/R5/R6/R11)", i), v, VECS[i][63:0]);
        end

        // Clean slate.
        wr(12'h403, '1); wr(12'h405, '1); wr(12'h407, '1); wr(12'h400, 64'h6);

        // R4: two-stage selection and gating.
        wr(12'h424, 64'd2);
        wr(12'h410, 64'h8000_0000_003C_0000);
        wr(12'h404, 64'h1);
        pulse(ev(2, 8'h3C), 2);
        rd(12'h421, v); chk("R4 global disable gates", v, 64'd0);
        wr(12'h400, 64'h1);
        rd(12'h400, v); chk("R2 enable bit reads back", v, 64'h3001);
        pulse(ev(2, 8'h3C), 5);
        pulse(ev(2, 8'h3D), 2);
        pulse(ev(3, 8'h3C), 2);
        rd(12'h421, v); chk("R4 selected event count", v, 64'd5);
        wr(12'h410, 64'h0000_0000_003C_0000);
        pulse(ev(2, 8'h3C), 3);
        rd(12'h421, v); chk("R4 master enable off", v, 64'd5);
        wr(12'h410, 64'h8000_0000_003C_0000);

        // R7/R8: event counter wrap.
        wr(12'h403, 64'h1);
        wr(12'h434, 64'd2);
        wr(12'h431, 64'hFFFF_FFFE);
        wr(12'h406, 64'h2);
        wr(12'h404, 64'h2);
        pulse(ev(2, 8'h3C), 1);
        rd(12'h431, v); chk("R7 below wrap", v, 64'hFFFF_FFFF);
        chk("R8 irq before wrap", {63'd0, irq_o}, 64'h0);
        pulse(ev(2, 8'h3C), 1);
        rd(12'h431, v); chk("R7 wrapped value", v, 64'h0);
        rd(12'h408, v); chk("R7 overflow bit", v, 64'h2);
        rd(12'h407, v); chk("R3 clear address reads map", v, 64'h2);
        chk("R8 irq after wrap", {63'd0, irq_o}, 64'h1);
        wr(12'h407, 64'h2);
        chk("R8 irq after clear", {63'd0, irq_o}, 64'h0);

        // R9: wrap in the same cycle as a software clear.
        wr(12'h431, 64'hFFFF_FFFF);
        wr(12'h408, 64'h2);
        @(negedge clk);
        addr_i = 12'h407; wr_data_i = 64'h2; wr_en_i = 1'b1;
        evt_pulse_i[ev(2, 8'h3C)] = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; evt_pulse_i = '0;
        rd(12'h431, v); chk("R9 counter wrapped", v, 64'h0);
        rd(12'h408, v); chk("R9 overflow kept", v, 64'h2);
        wr(12'h407, 64'h2);

        // R10: software load in the same cycle as an event.
        @(negedge clk);
        addr_i = 12'h431; wr_data_i = 64'h100; wr_en_i = 1'b1;
        evt_pulse_i[ev(2, 8'h3C)] = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; evt_pulse_i = '0;
        rd(12'h431, v); chk("R10 load wins", v, 64'h100);

        // R5/R7: cycle counter counts two cycles and wraps.
        wr(12'h400, 64'h0);
        wr(12'h403, 64'h2);
        wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(12'h404, 64'h8000_0000);
        wr(12'h406, 64'h8000_0000);
        rd(12'h40A, v); chk("R5 no count while disabled", v, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(12'h400, 64'h1);
        wr(12'h400, 64'h0);
        rd(12'h40A, v); chk("R5/R7 cycle wrap value", v, 64'h0);
        rd(12'h408, v); chk("R7 cycle overflow bit 31", v, 64'h8000_0000);
        chk("R8 irq from cycle counter", {63'd0, irq_o}, 64'h1);
        wr(12'h407, 64'h8000_0000);

        // R2: selective zeroing.
        wr(12'h40A, 64'd5);
        wr(12'h451, 64'd9);
        wr(12'h400, 64'h2);
        rd(12'h451, v); chk("R2 event counters zeroed", v, 64'd0);
        rd(12'h40A, v); chk("R2 cycle kept on bit 1", v, 64'd5);
        wr(12'h400, 64'h4);
        rd(12'h40A, v); chk("R2 cycle zeroed on bit 2", v, 64'd0);

        // R12: read data holds without a strobe.
        wr(12'h40A, 64'h77);
        rd(12'h40A, held);
        wr(12'h40A, 64'h99);
        @(negedge clk);
        chk("R12 read data holds", rd_data_o, 64'h77);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule